// File: doc/BRIEF.md
# Character Blink and Reverse-Video Pixel Gate

This block produces the pixel value for one character of an on-screen text overlay. It counts fields by watching for the active edge of vertical sync. It splits each blink period into a visible part and a hidden part, and applies each character's blink and reverse-video attributes to the pixel that the font store supplies. The font lookup and the sync separator sit outside the block. The block receives the raw font pixel, the character code and the two attribute bits, and it returns one registered pixel.

The blink period is a whole number of fields. A 2-bit select chooses it from a set tuned to 50 Hz and 60 Hz field rates. The visible part always covers the first three fifths of the period, which gives a 60/40 duty. A small state machine tracks the phase. It has two states. PH_SHOW is the visible part and PH_HIDE is the hidden part. The transitions are:
- show_to_hide: taken on the field edge that makes the count equal the visible length.
- hide_to_show: taken on the field edge that wraps the count to 0.
- restart: taken from either state when the period select changes. It returns the machine to PH_SHOW with a count of 0.

Top module: `blink_gate_top`

## Requirements
- R1: `period_sel` codes 2'b00, 2'b01, 2'b10 and 2'b11 give blink periods of 25, 30, 50 and 60 fields. After that many active sync edges the phase returns to visible.
- R2: The character is visible during the first 15, 18, 30 or 36 fields of each period (count values 0 up to that number minus one). It is hidden for the rest of the period.
- R3: A character is blanked in the hidden phase only when both `attr_blink` and `blink_en` are 1. Otherwise the phase has no effect on it.
- R4: When both `attr_reverse` and `reverse_en` are 1, the font pixel is inverted. Blink gating is applied after the inversion, so a hidden reversed character outputs 0.
- R5: When `vsync_pol` is 1, a field edge is a 0-to-1 change of `vsync_in`. When it is 0, a field edge is a 1-to-0 change. Changing `vsync_pol` while `vsync_in` holds steady is not a field edge.
- R6: Character code 8'hFE always outputs 0, whatever its attributes and font pixel.
- R7: The field count advances by exactly one per detected field edge. The first cycle after reset only samples `vsync_in` and never counts an edge.
- R8: Reset, or any change of `period_sel`, puts the count at 0 in the visible phase. During reset `pix_out` is 0.
- R9: `pix_out` is registered. It reflects the inputs and the phase of the preceding clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsync_in | input | 1 | Vertical sync, level as received |
| vsync_pol | input | 1 | 1: sync is high-active, 0: sync is low-active |
| period_sel | input | 2 | Blink period select (25/30/50/60 fields) |
| blink_en | input | 1 | Global blink enable |
| reverse_en | input | 1 | Global reverse-video enable |
| attr_blink | input | 1 | Blink attribute of the current character |
| attr_reverse | input | 1 | Reverse attribute of the current character |
| char_code | input | 8 | Code of the current character |
| font_px | input | 1 | Raw font pixel for the current position |
| pix_out | output | 1 | Gated pixel, registered |

## Verification
On every cycle, the assertions check four things: the blank code stays dark, the pixel passes through or is inverted as the attributes require, the field count stays inside the longest period and moves only by one step or back to 0, and a change of select restarts the count. Three behaviours can only be shown by the bench's scenarios, because each depends on a history of many fields: that each select code produces exactly its period, that the visible window has exactly its length, and that a polarity switch on a steady sync line is not counted as a field. The bench shows these by running full periods for every code and comparing them against its own model of the field count.

// File: rtl/blink_pkg.sv
package blink_pkg;

    typedef enum logic [0:0] {
        PH_SHOW = 1'b0,
        PH_HIDE = 1'b1
    } phase_e;

    // 3/5 of a period, the visible share of every blink cycle
    function automatic int vis_of(input int period);
        return (period * 3) / 5;
    endfunction

endpackage

// File: rtl/vs_edge_det.sv
module vs_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_raw,
    input  logic vs_pol,
    output logic fld_edge
);
    logic prev_q;
    logic primed_q;

    // Previous raw level is stored, so the polarity choice is applied to
    // both samples at once and a polarity switch alone cannot look like an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= vs_raw;
            primed_q <= 1'b1;
        end
    end

    always_comb begin
        if (!primed_q)
            fld_edge = 1'b0;
        else if (vs_pol)
            fld_edge = vs_raw & ~prev_q;
        else
            fld_edge = ~vs_raw & prev_q;
    end

endmodule

// File: rtl/blink_phase_fsm.sv
module blink_phase_fsm
    import blink_pkg::*;
#(
    parameter int P0    = 25,
    parameter int P1    = 30,
    parameter int P2    = 50,
    parameter int P3    = 60,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fld_edge,
    input  logic [1:0]       sel,
    output logic             show,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LEN0 = CNT_W'(P0);
    localparam logic [CNT_W-1:0] LEN1 = CNT_W'(P1);
    localparam logic [CNT_W-1:0] LEN2 = CNT_W'(P2);
    localparam logic [CNT_W-1:0] LEN3 = CNT_W'(P3);
    localparam logic [CNT_W-1:0] VIS0 = CNT_W'(vis_of(P0));
    localparam logic [CNT_W-1:0] VIS1 = CNT_W'(vis_of(P1));
    localparam logic [CNT_W-1:0] VIS2 = CNT_W'(vis_of(P2));
    localparam logic [CNT_W-1:0] VIS3 = CNT_W'(vis_of(P3));

    phase_e           state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [1:0]       sel_q;
    logic [CNT_W-1:0] len_cur, vis_cur;
    logic             restart;

    always_comb begin
        unique case (sel_q)
            2'd0: begin len_cur = LEN0; vis_cur = VIS0; end
            2'd1: begin len_cur = LEN1; vis_cur = VIS1; end
            2'd2: begin len_cur = LEN2; vis_cur = VIS2; end
            default: begin len_cur = LEN3; vis_cur = VIS3; end
        endcase
    end

    assign restart = (sel != sel_q);

    // next count
    always_comb begin
        cnt_n = cnt_q;
        if (restart)
            cnt_n = '0;
        else if (fld_edge)
            cnt_n = (cnt_q == len_cur - 1'b1) ? '0 : cnt_q + 1'b1;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            PH_SHOW: begin
                if (restart)
                    state_n = PH_SHOW;
                else if (fld_edge && cnt_n == vis_cur)
                    state_n = PH_HIDE;           // show_to_hide
            end
            PH_HIDE: begin
                if (restart)
                    state_n = PH_SHOW;           // restart
                else if (fld_edge && cnt_n == '0)
                    state_n = PH_SHOW;           // hide_to_show
            end
            default: state_n = PH_SHOW;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_SHOW;
            cnt_q   <= '0;
            sel_q   <= 2'd0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            sel_q   <= sel;
        end
    end

    // outputs
    always_comb begin
        show  = (state_q == PH_SHOW);
        cnt_o = cnt_q;
    end

endmodule

// File: rtl/attr_pixel_gate.sv
module attr_pixel_gate #(
    parameter int              CODE_W     = 8,
    parameter logic [CODE_W-1:0] BLANK_CODE = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              show,
    input  logic              blink_en,
    input  logic              reverse_en,
    input  logic              attr_blink,
    input  logic              attr_reverse,
    input  logic [CODE_W-1:0] char_code,
    input  logic              font_px,
    output logic              pix_out
);
    logic px_rev;
    logic hide;
    logic px_n;

    always_comb begin
        px_rev = font_px ^ (reverse_en & attr_reverse);
        hide   = blink_en & attr_blink & ~show;
        px_n   = (char_code != BLANK_CODE) & ~hide & px_rev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pix_out <= 1'b0;
        else
            pix_out <= px_n;
    end

endmodule

// File: rtl/blink_gate_top.sv
module blink_gate_top #(
    parameter int              P0         = 25,
    parameter int              P1         = 30,
    parameter int              P2         = 50,
    parameter int              P3         = 60,
    parameter int              CODE_W     = 8,
    parameter logic [CODE_W-1:0] BLANK_CODE = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_in,
    input  logic              vsync_pol,
    input  logic [1:0]        period_sel,
    input  logic              blink_en,
    input  logic              reverse_en,
    input  logic              attr_blink,
    input  logic              attr_reverse,
    input  logic [CODE_W-1:0] char_code,
    input  logic              font_px,
    output logic              pix_out
);
    localparam int PMAX01 = (P0 > P1) ? P0 : P1;
    localparam int PMAX23 = (P2 > P3) ? P2 : P3;
    localparam int PMAX   = (PMAX01 > PMAX23) ? PMAX01 : PMAX23;
    localparam int CNT_W  = $clog2(PMAX + 1);

    logic             fld_edge;
    logic             show_phase;
    logic [CNT_W-1:0] field_cnt;

    vs_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .vs_raw   (vsync_in),
        .vs_pol   (vsync_pol),
        .fld_edge (fld_edge)
    );

    blink_phase_fsm #(
        .P0(P0), .P1(P1), .P2(P2), .P3(P3), .CNT_W(CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fld_edge (fld_edge),
        .sel      (period_sel),
        .show     (show_phase),
        .cnt_o    (field_cnt)
    );

    attr_pixel_gate #(
        .CODE_W(CODE_W), .BLANK_CODE(BLANK_CODE)
    ) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .show         (show_phase),
        .blink_en     (blink_en),
        .reverse_en   (reverse_en),
        .attr_blink   (attr_blink),
        .attr_reverse (attr_reverse),
        .char_code    (char_code),
        .font_px      (font_px),
        .pix_out      (pix_out)
    );

endmodule

// File: rtl/blink_gate_chk.sv
module blink_gate_chk #(
    parameter int              CNT_W      = 6,
    parameter int              PMAX       = 60,
    parameter int              CODE_W     = 8,
    parameter logic [CODE_W-1:0] BLANK_CODE = 8'hFE
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        period_sel,
    input logic              blink_en,
    input logic              reverse_en,
    input logic              attr_blink,
    input logic              attr_reverse,
    input logic [CODE_W-1:0] char_code,
    input logic              font_px,
    input logic              pix_out,
    input logic              show_phase,
    input logic [CNT_W-1:0]  field_cnt
);
    // R6
    p_blank_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_code == BLANK_CODE) |=> !pix_out);

    // R3 and R9: no attribute in force, so the pixel passes through one cycle later
    p_plain_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((char_code != BLANK_CODE) && !(blink_en && attr_blink) && !(reverse_en && attr_reverse))
        |=> (pix_out == $past(font_px)));

    // R4
    p_reverse_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((char_code != BLANK_CODE) && reverse_en && attr_reverse && !(blink_en && attr_blink))
        |=> (pix_out == !$past(font_px)));

    // R2: a hidden blinking character stays dark
    p_hidden_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && attr_blink && !show_phase) |=> !pix_out);

    // R1
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        field_cnt < CNT_W'(PMAX));

    // R7
    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (field_cnt != $past(field_cnt)) |->
        ((field_cnt == $past(field_cnt) + 1'b1) || (field_cnt == '0)));

    // R8
    p_sel_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_sel != $past(period_sel)) |=> ((field_cnt == '0) && show_phase));

    // R2: count 0 always lies in the visible part
    p_zero_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (field_cnt == '0) |-> show_phase);

endmodule

bind blink_gate_top blink_gate_chk #(
    .CNT_W(CNT_W), .PMAX(PMAX), .CODE_W(CODE_W), .BLANK_CODE(BLANK_CODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_sel   (period_sel),
    .blink_en     (blink_en),
    .reverse_en   (reverse_en),
    .attr_blink   (attr_blink),
    .attr_reverse (attr_reverse),
    .char_code    (char_code),
    .font_px      (font_px),
    .pix_out      (pix_out),
    .show_phase   (show_phase),
    .field_cnt    (field_cnt)
);

// File: tb/blink_gate_top_tb.sv
module blink_gate_top_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       vsync_in;
    logic       vsync_pol;
    logic [1:0] period_sel;
    logic       blink_en;
    logic       reverse_en;
    logic       attr_blink;
    logic       attr_reverse;
    logic [7:0] char_code;
    logic       font_px;
    logic       pix_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // bench model state
    int m_cnt;
    int m_selq;
    bit m_prev;
    bit m_primed;

    always #2 clk = ~clk;   // 250 MHz

    blink_gate_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .vsync_in     (vsync_in),
        .vsync_pol    (vsync_pol),
        .period_sel   (period_sel),
        .blink_en     (blink_en),
        .reverse_en   (reverse_en),
        .attr_blink   (attr_blink),
        .attr_reverse (attr_reverse),
        .char_code    (char_code),
        .font_px      (font_px),
        .pix_out      (pix_out)
    );

    function automatic int period_len(input int s);
        case (s)
            0: return 25;
            1: return 30;
            2: return 50;
            default: return 60;
        endcase
    endfunction

    function automatic int vis_len(input int s);
        case (s)
            0: return 15;
            1: return 18;
            2: return 30;
            default: return 36;
        endcase
    endfunction

    function automatic bit exp_pix(input bit vis);
        bit p;
        if (char_code == 8'hFE) return 1'b0;
        p = font_px ^ (reverse_en & attr_reverse);
        if (blink_en && attr_blink && !vis) return 1'b0;
        return p;
    endfunction

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_selq = 0; m_prev = 1'b0; m_primed = 1'b0;
    endtask

    // one clock: expected value from model before the edge, update model, compare after
    task automatic step(input string tag);
        bit e;
        bit edge_m;
        e = exp_pix(m_cnt < vis_len(m_selq));
        edge_m = m_primed && (vsync_pol ? (vsync_in && !m_prev) : (!vsync_in && m_prev));
        @(posedge clk);
        if (int'(period_sel) != m_selq) begin
            m_cnt = 0;
            m_selq = int'(period_sel);
        end else if (edge_m) begin
            m_cnt = (m_cnt == period_len(m_selq) - 1) ? 0 : m_cnt + 1;
        end
        m_prev = vsync_in;
        m_primed = 1'b1;
        #1;
        check(tag, pix_out, e);
    endtask

    // one field: active level one cycle, idle one cycle
    task automatic field(input string tag);
        vsync_in = vsync_pol;
        step(tag);
        vsync_in = ~vsync_pol;
        step(tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int shown;
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        vsync_in = 1'b0; vsync_pol = 1'b1; period_sel = 2'd0;
        blink_en = 1'b1; reverse_en = 1'b0; attr_blink = 1'b1; attr_reverse = 1'b0;
        char_code = 8'h41; font_px = 1'b1;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset", pix_out, 1'b0);
        rst_n = 1'b1;
        step("R7 first cycle");

        // R1 / R2: full periods for every select code
        for (int s = 0; s < 4; s++) begin
            period_sel = 2'(s);
            step("R8 select change");
            shown = 0;
            for (int f = 0; f < period_len(s); f++) begin
                if (pix_out) shown++;
                field("R1 period sweep");
            end
            checks++;
            if (shown != vis_len(s)) begin
                failures++;
                $display("FAIL R2 visible fields sel=%0d actual=%0d expected=%0d", s, shown, vis_len(s));
            end
            for (int f = 0; f < 8; f++) field("R1 wrap");
        end

        // R5: polarity switch on a steady line is not a field edge
        period_sel = 2'd1; step("R8 select change");
        period_sel = 2'd0; step("R8 select change");
        vsync_pol = 1'b1; vsync_in = 1'b0;
        for (int f = 0; f < 14; f++) field("R5 rising fields");
        vsync_pol = 1'b0;            // line low, now the active level
        repeat (4) step("R5 pol switch no edge");
        vsync_in = 1'b1; step("R5 idle high");
        vsync_in = 1'b0; step("R5 falling edge");
        repeat (3) step("R2 now hidden");

        // R3 / R4 / R6 directed in the hidden phase
        attr_blink = 1'b0; step("R3 no attr visible");
        attr_blink = 1'b1; blink_en = 1'b0; step("R3 global off");
        blink_en = 1'b1; attr_reverse = 1'b1; reverse_en = 1'b1; font_px = 1'b0;
        step("R4 reversed but hidden");
        attr_blink = 1'b0; step("R4 reversed visible");
        char_code = 8'hFE; step("R6 blank code");

        // random stimulus
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(99) < 30) vsync_in = ~vsync_in;
            if ($urandom_range(999) < 3) vsync_pol = ~vsync_pol;
            if ($urandom_range(999) < 2) period_sel = 2'($urandom_range(3));
            if ($urandom_range(99) < 2) blink_en = ~blink_en;
            if ($urandom_range(99) < 2) reverse_en = ~reverse_en;
            attr_blink   = 1'($urandom_range(1));
            attr_reverse = 1'($urandom_range(1));
            font_px      = 1'($urandom_range(1));
            char_code    = ($urandom_range(7) == 0) ? 8'hFE : 8'($urandom_range(255));
            step("R9 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule